// File: doc/BRIEF.md
# Sine Reference Address Generator

This block supplies the local carrier reference to a coherent binary phase shift keying correlator. It holds a phase address into one full cycle of a sine wave that is divided into a parameterised number of points (10,000 by default). On every sample-enabled clock it reads the sample at the current address and then advances the address by a fixed step. The step is derived at elaboration from carrier-frequency and sampling-frequency parameters. The table size is not a power of two, so the address wraps modulo the table size and not by binary overflow.

Each sample is a 14-bit binary-offset value. The zero level is 0x1FFF, the positive peak is 0x3FFE and the negative peak is 0x0000. The design builds the table itself from a quarter-wave magnitude table and folds it into the full cycle. Each sample comes out one clock after its read, together with a valid flag and the address it was read from, so the correlator can line it up with ADC data. A synchronous phase clear puts the address back to zero, so the reference can start again at a bit boundary. The sample enable lets a fast system clock run the table at a lower effective sampling rate.

Top module: `sine_ref_gen`

## Requirements
- R1: While reset is held and directly after it is released, `ref_valid_o` is 0, `ref_sample_o` is 0x1FFF and `ref_phase_o` is 0.
- R2: The address step equals floor(TABLE_N × CARRIER_HZ / SAMPLE_HZ). It is 15 for an 18 kHz carrier at 12 MHz, 40 for 48 kHz and 25 for 30 kHz. Two successive enabled reads with no wrap and no clear between them report addresses that differ by exactly that step.
- R3: When address + step ≥ TABLE_N, the next address is address + step − TABLE_N. For example, 9990 is followed by 5 at step 15, and 9960 is followed by 0 at step 40.
- R4: A high `phase_clr` sets the address to 0 at the next clock edge, with priority over `sample_en`. No read takes place on that clock, so `ref_valid_o` is 0 on the following clock, and the next enabled read reports address 0.
- R5: On a clock where `sample_en` is low, the address does not change, and the next enabled read reports the same address as before the idle clocks.
- R6: A read takes place on each clock where `sample_en` is high and `phase_clr` is low. On the clock after such a read, `ref_valid_o` is 1 and `ref_phase_o` holds the address that was read. On every other clock `ref_valid_o` is 0.
- R7: A valid sample at address a equals 0x1FFF + round(8191 × sin(2πa/TABLE_N)) to within 1 LSB. It is exactly 0x1FFF at a = 0 and at a = TABLE_N/2, exactly 0x3FFE at a = TABLE_N/4, and exactly 0x0000 at a = 3·TABLE_N/4.
- R8: On a clock where `ref_valid_o` is 0, `ref_sample_o` and `ref_phase_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Reads the table at the current address and advances the address |
| phase_clr | input | 1 | Synchronous return of the address to zero; overrides sample_en |
| ref_sample_o | output | 14 | Binary-offset sine sample, zero level 0x1FFF |
| ref_valid_o | output | 1 | A new sample is on ref_sample_o this clock |
| ref_phase_o | output | 14 | Table address the present sample was read from |

## Verification
The properties assume that `sample_en` and `phase_clr` are clean, synchronous levels that are valid at every edge after reset. They may take any combination, including both high at once. The properties also assume that the step derived from the parameters is below the table size and that the table size is a multiple of four. The stimulus changes the inputs only on the falling clock edge. Long runs of continuous enable cross the wrap point of every configured step. Random stretches mix idle clocks with occasional clears, some of which land together with an enable. All three instances in the bench use parameter sets whose step is well below the table size.

// File: rtl/sine_ref_pkg.sv
package sine_ref_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Magnitude of sin(pi/2 * idx/qtr) scaled to full_scale, Taylor series in reals
  function automatic int unsigned quarter_mag(input int unsigned idx,
                                              input int unsigned qtr,
                                              input int unsigned full_scale);
    real x, term, acc;
    x    = (TWO_PI / 4.0) * real'(idx) / real'(qtr);
    term = x;
    acc  = x;
    for (int k = 1; k < 12; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    if (acc < 0.0) acc = 0.0;
    quarter_mag = int'(acc * real'(full_scale));
    if (quarter_mag > full_scale) quarter_mag = full_scale;
  endfunction

  // Step per sample: table size scaled by carrier over sampling rate
  function automatic int unsigned phase_step(input longint unsigned tab_n,
                                             input longint unsigned carrier_hz,
                                             input longint unsigned sample_hz);
    phase_step = int'((tab_n * carrier_hz) / sample_hz);
  endfunction

endpackage

// File: rtl/sine_ref_phase.sv
module sine_ref_phase #(
  parameter int unsigned TABLE_N = 10000,
  parameter int unsigned STEP    = 15,
  parameter int unsigned AW      = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  output logic [AW-1:0] addr_o,
  output logic          wrap_o
);

  localparam logic [AW:0] STEP_X = AW'(STEP);
  localparam logic [AW:0] N_X    = (AW+1)'(TABLE_N);

  function automatic logic [AW:0] raw_sum(input logic [AW-1:0] a);
    raw_sum = {1'b0, a} + STEP_X;
  endfunction

  logic [AW:0]   sum;
  logic [AW-1:0] nxt;

  always_comb begin
    sum    = raw_sum(addr_o);
    wrap_o = (sum >= N_X);
    nxt    = wrap_o ? AW'(sum - N_X) : sum[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_o <= '0;
    else if (clr)    addr_o <= '0;
    else if (adv)    addr_o <= nxt;
  end

endmodule

// File: rtl/sine_ref_rom.sv
module sine_ref_rom
  import sine_ref_pkg::*;
#(
  parameter int unsigned TABLE_N  = 10000,
  parameter int unsigned AW       = 14,
  parameter int unsigned SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic [SAMPLE_W-1:0] sample_o
);

  localparam int unsigned QTR   = TABLE_N / 4;
  localparam int unsigned HALF  = TABLE_N / 2;
  localparam int unsigned MAG_W = SAMPLE_W - 1;
  localparam int unsigned MID   = (1 << MAG_W) - 1;
  localparam int unsigned QW    = $clog2(QTR + 1);

  logic [MAG_W-1:0] qtab [QTR+1];

  for (genvar i = 0; i <= QTR; i++) begin : g_qtab
    localparam logic [MAG_W-1:0] QV = MAG_W'(quarter_mag(i, QTR, MID));
    assign qtab[i] = QV;
  end

  logic [AW-1:0]     in_half;
  logic              neg_half;
  logic              falling;
  logic [QW-1:0]     qidx;
  logic [MAG_W-1:0]  mag;
  logic [SAMPLE_W-1:0] folded;

  always_comb begin
    neg_half = (rd_addr >= AW'(HALF));
    in_half  = neg_half ? AW'(rd_addr - AW'(HALF)) : rd_addr;
    falling  = (in_half >= AW'(QTR));
    qidx     = falling ? QW'(AW'(HALF) - in_half) : QW'(in_half);
    mag      = qtab[qidx];
    folded   = neg_half ? SAMPLE_W'(MID - mag) : SAMPLE_W'(MID + mag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sample_o <= SAMPLE_W'(MID);
    else if (rd_en) sample_o <= folded;
  end

endmodule

// File: rtl/sine_ref_gen.sv
module sine_ref_gen
  import sine_ref_pkg::*;
#(
  parameter int unsigned TABLE_N    = 10000,
  parameter int unsigned SAMPLE_W   = 14,
  parameter int unsigned CARRIER_HZ = 18000,
  parameter int unsigned SAMPLE_HZ  = 12000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                phase_clr,
  output logic [SAMPLE_W-1:0] ref_sample_o,
  output logic                ref_valid_o,
  output logic [13:0]         ref_phase_o
);

  localparam int unsigned AW   = 14;
  localparam int unsigned STEP = phase_step(TABLE_N, CARRIER_HZ, SAMPLE_HZ);

  logic          rd_evt;
  logic          wrap_evt;
  logic          wrap_raw;
  logic [AW-1:0] addr_q;

  assign rd_evt   = sample_en & ~phase_clr;
  assign wrap_evt = rd_evt & wrap_raw;

  sine_ref_phase #(.TABLE_N(TABLE_N), .STEP(STEP), .AW(AW)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (rd_evt),
    .clr    (phase_clr),
    .addr_o (addr_q),
    .wrap_o (wrap_raw)
  );

  sine_ref_rom #(.TABLE_N(TABLE_N), .AW(AW), .SAMPLE_W(SAMPLE_W)) u_rom (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_evt),
    .rd_addr  (addr_q),
    .sample_o (ref_sample_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_valid_o <= 1'b0;
      ref_phase_o <= '0;
    end else begin
      ref_valid_o <= rd_evt;
      if (rd_evt) ref_phase_o <= addr_q;
    end
  end

endmodule

// File: rtl/sine_ref_chk.sv
module sine_ref_chk #(
  parameter int unsigned TABLE_N  = 10000,
  parameter int unsigned STEP     = 15,
  parameter int unsigned SAMPLE_W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_en,
  input logic                phase_clr,
  input logic [SAMPLE_W-1:0] ref_sample_o,
  input logic                ref_valid_o,
  input logic [13:0]         ref_phase_o,
  input logic [13:0]         addr_q,
  input logic                wrap_evt
);

  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'((1 << (SAMPLE_W - 1)) - 1);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !phase_clr && !wrap_evt) |=> addr_q == $past(addr_q) + 14'(STEP));

  // R3
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (addr_q < 14'(STEP)) && (addr_q == 14'($past(addr_q) + 14'(STEP) - 14'(TABLE_N))));

  // R4
  phase_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> (addr_q == 14'd0) && !ref_valid_o);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !phase_clr) |=> $stable(addr_q));

  // R6
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !phase_clr) |=> ref_valid_o && (ref_phase_o == $past(addr_q)));

  // R7
  zero_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid_o && ref_phase_o == 14'd0) |-> ref_sample_o == MID);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid_o |-> ($stable(ref_sample_o) && $stable(ref_phase_o)));

  // R3
  always @(posedge clk) begin
    if (rst_n) addr_range_chk: assert (addr_q < 14'(TABLE_N));
  end

endmodule

bind sine_ref_gen sine_ref_chk #(.TABLE_N(TABLE_N), .STEP(STEP), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_en    (sample_en),
  .phase_clr    (phase_clr),
  .ref_sample_o (ref_sample_o),
  .ref_valid_o  (ref_valid_o),
  .ref_phase_o  (ref_phase_o),
  .addr_q       (addr_q),
  .wrap_evt     (wrap_evt)
);

// File: tb/sine_ref_gen_tb.sv
module sine_ref_gen_tb;

  localparam int N = 10000;

  logic clk = 1'b0;
  logic rst_n;
  logic sample_en;
  logic phase_clr;

  always #2 clk = ~clk;

  logic [13:0] smp [3];
  logic        vld [3];
  logic [13:0] phs [3];

  sine_ref_gen #(.CARRIER_HZ(18000)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .phase_clr(phase_clr),
    .ref_sample_o(smp[0]), .ref_valid_o(vld[0]), .ref_phase_o(phs[0]));
  sine_ref_gen #(.CARRIER_HZ(48000)) u_dut48 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .phase_clr(phase_clr),
    .ref_sample_o(smp[1]), .ref_valid_o(vld[1]), .ref_phase_o(phs[1]));
  sine_ref_gen #(.CARRIER_HZ(30000)) u_dut30 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .phase_clr(phase_clr),
    .ref_sample_o(smp[2]), .ref_valid_o(vld[2]), .ref_phase_o(phs[2]));

  int steps [3] = '{15, 40, 25};
  int m_addr [3];
  int last_smp [3];
  int last_phs [3];
  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  function automatic int exp_sine(input int a);
    real v;
    v = 8191.0 * $sin(6.283185307179586 * real'(a) / real'(N));
    return 8191 + int'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // One clock: apply inputs at falling edge, check after the next rising edge
  task automatic tick(input bit en, input bit clr);
    sample_en = en;
    phase_clr = clr;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      if (clr) begin
        check(vld[k] == 1'b0, "R4 valid after clear", int'(vld[k]), 0);
        check(int'(smp[k]) == last_smp[k], "R8 sample hold", int'(smp[k]), last_smp[k]);
        m_addr[k] = 0;
      end else if (en) begin
        int e;
        int d;
        e = exp_sine(m_addr[k]);
        d = int'(smp[k]) - e;
        check(vld[k] == 1'b1, "R6 valid after read", int'(vld[k]), 1);
        check(int'(phs[k]) == m_addr[k],
              (m_addr[k] < steps[k]) ? "R3 address after wrap" : "R2 address step",
              int'(phs[k]), m_addr[k]);
        if (m_addr[k] % (N / 4) == 0)
          check(d == 0, "R7 exact quarter point", int'(smp[k]), e);
        else
          check(d <= 1 && d >= -1, "R7 sample value", int'(smp[k]), e);
        m_addr[k] = m_addr[k] + steps[k];
        if (m_addr[k] >= N) m_addr[k] = m_addr[k] - N;
      end else begin
        check(vld[k] == 1'b0, "R6 no valid when idle", int'(vld[k]), 0);
        check(int'(smp[k]) == last_smp[k], "R8 sample hold", int'(smp[k]), last_smp[k]);
        check(int'(phs[k]) == last_phs[k], "R5 phase hold", int'(phs[k]), last_phs[k]);
      end
      last_smp[k] = int'(smp[k]);
      last_phs[k] = int'(phs[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    sample_en = 1'b0;
    phase_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      check(vld[k] == 1'b0, "R1 reset valid", int'(vld[k]), 0);
      check(smp[k] == 14'h1FFF, "R1 reset sample", int'(smp[k]), 'h1FFF);
      check(phs[k] == 14'd0, "R1 reset phase", int'(phs[k]), 0);
      m_addr[k] = 0;
      last_smp[k] = int'(smp[k]);
      last_phs[k] = int'(phs[k]);
    end
    // R3: continuous enable across the wrap of every step (9990->5, 9960->0)
    for (int i = 0; i < 700; i++) tick(1'b1, 1'b0);
    // R5: idle stretch, then resume at same address
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    // R4: clear together with enable, then read of address 0
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    // Random mix of enables, idles and clears
    for (int i = 0; i < 6000; i++)
      tick(($urandom % 4) != 0, ($urandom % 80) == 0);
    // Long run without clear to visit every quarter point (R7)
    for (int i = 0; i < 1500; i++) tick(1'b1, 1'b0);
    finished = 1'b1;
    summary();
  end

endmodule